// File: doc/BRIEF.md
# Trip Event Routing Crossbar

This block feeds the fault inputs of a PWM stage. It produces eight trip outputs from a shared pool of event signals. The pool is split into 32 groups, and each group holds four candidate lines. For every output, each group has its own four-way selector and its own enable bit. Each selector picks one candidate from its group. The selections of all enabled groups are ORed together. An optional per-output inversion is then applied to the result.

Configuration is written through a plain synchronous port with address, data and write strobe. The routing path from the event pool to the trip outputs is purely combinational, so a fault event reaches the PWM without any clock delay. Some candidate positions have no source behind them. These positions always read as low.

Top module: `trip_route_xbar`

## Requirements
- R1: The eight outputs are configured independently. A write aimed at one output's registers changes no other output.
- R2: The select fields for output o are held in two registers:
  - groups 0–15 at address 4·o;
  - groups 16–31 at address 4·o+1.
  Group g uses bits [2·(g mod 16)+1 : 2·(g mod 16)]. Value c selects candidate c of group g, which is evt_pool[4·g+c].
- R3: The enable register of output o is at address 4·o+2, and bit g enables group g. A group whose enable bit is clear has no effect on the output.
- R4: Each output is the OR of the selected candidates of all its enabled groups.
- R5: The inversion register is at address 32, and bit o inverts output o. Inversion acts after the OR, so an output with no enabled groups and its inversion bit set drives 1.
- R6: Some candidate positions are reserved and always read as 0:
  - candidate 2 of groups 16, 18, 20, 22, 24, 26, 28, 30 and 31;
  - candidate 3 of groups 20, 21, 22, 23, 24, 26, 28 and 30.
- R7: Reset clears every configuration register, and every trip output is 0 while reset is held and after it is released.
- R8: A write takes effect at the rising clock edge that samples the strobe high. The output does not change before that edge. A change on evt_pool reaches trip_out in the same cycle.
- R9: Writes to unmapped addresses change nothing. The unmapped addresses are 4·o+3 and every address above 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| evt_pool | input | 128 | Event candidates, group g candidate c at bit 4·g+c |
| trip_out | output | 8 | Trip outputs to the PWM fault path |

## Verification
The bench builds the block with its default parameters: eight outputs, 32 groups of four candidates, 32-bit data and the default reserved-position map. With these values both select registers of every output are reachable, including the top select field (group 31) and the reserved holes in the upper half of the groups. The full address map can also be exercised, including its unmapped gaps. A reference model inside the bench tracks the configuration it has written and recomputes all eight outputs after every stimulus. As a result, any leak of one output's configuration into another shows up at once.

// File: rtl/trip_xbar_pkg.sv
`timescale 1ns/1ps
package trip_xbar_pkg;

  localparam int unsigned DEF_GROUPS = 32;
  localparam int unsigned DEF_CANDS  = 4;

  // Default map of unconnected candidate positions, bit 4*g+c.
  function automatic logic [DEF_GROUPS*DEF_CANDS-1:0] hole_map_build();
    logic [DEF_GROUPS*DEF_CANDS-1:0] m;
    m = '0;
    for (int g = 16; g < 32; g++) begin
      if ((g % 2) == 0 || g == 31) m[g*4+2] = 1'b1;
      if ((g >= 20 && g <= 24) || g == 26 || g == 28 || g == 30) m[g*4+3] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DEF_GROUPS*DEF_CANDS-1:0] HOLE_MAP_DEFAULT = hole_map_build();

endpackage

// File: rtl/trip_xbar_rst_sync.sv
`timescale 1ns/1ps
module trip_xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_core_n = stage_q[1];
endmodule

// File: rtl/trip_xbar_regs.sv
`timescale 1ns/1ps
module trip_xbar_regs #(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_GRP  = 32,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [N_OUT*N_GRP*SEL_W-1:0]  sel_flat,
  output logic [N_OUT*N_GRP-1:0]        en_flat,
  output logic [N_OUT-1:0]              inv_q
);
  localparam int unsigned GRP_PER_REG = DATA_W / SEL_W;
  localparam int unsigned SEL_REGS    = N_GRP / GRP_PER_REG;
  localparam int unsigned SLOT_W      = $clog2(SEL_REGS + 1);
  localparam int unsigned EN_SLOT     = SEL_REGS;
  localparam logic [ADDR_W-1:0] INV_ADDR = ADDR_W'(N_OUT << SLOT_W);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar r = 0; r < SEL_REGS; r++) begin : g_sel
      logic              hit;
      logic [DATA_W-1:0] sel_q;
      logic [DATA_W-1:0] sel_d;

      assign hit = wr_en && (wr_addr == ADDR_W'((o << SLOT_W) + r));

      always_comb begin
        sel_d = sel_q;
        if (hit) sel_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sel_q <= '0;
        else if (hit) sel_q <= sel_d;
      end

      assign sel_flat[o*N_GRP*SEL_W + r*DATA_W +: DATA_W] = sel_q;
    end

    logic             en_hit;
    logic [N_GRP-1:0] en_q;
    logic [N_GRP-1:0] en_d;

    assign en_hit = wr_en && (wr_addr == ADDR_W'((o << SLOT_W) + EN_SLOT));

    always_comb begin
      en_d = en_q;
      if (en_hit) en_d = wr_data[N_GRP-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (en_hit) en_q <= en_d;
    end

    assign en_flat[o*N_GRP +: N_GRP] = en_q;
  end

  logic             inv_hit;
  logic [N_OUT-1:0] inv_d;

  assign inv_hit = wr_en && (wr_addr == INV_ADDR);

  always_comb begin
    inv_d = inv_q;
    if (inv_hit) inv_d = wr_data[N_OUT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       inv_q <= '0;
    else if (inv_hit) inv_q <= inv_d;
  end

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[DATA_W-1:N_OUT];
endmodule

// File: rtl/trip_xbar_pick.sv
`timescale 1ns/1ps
module trip_xbar_pick #(
  parameter int unsigned N_CAND = 4,
  parameter int unsigned SEL_W  = 2,
  parameter logic [N_CAND-1:0] HOLE = '0
) (
  input  logic [N_CAND-1:0] cand,
  input  logic [SEL_W-1:0]  sel,
  output logic              pick
);
  logic [N_CAND-1:0] live;

  assign live = cand & ~HOLE;

  always_comb begin
    pick = 1'b0;
    for (int c = 0; c < N_CAND; c++) begin
      if (sel == SEL_W'(c)) pick = live[c];
    end
  end
endmodule

// File: rtl/trip_xbar_lane.sv
`timescale 1ns/1ps
module trip_xbar_lane #(
  parameter int unsigned N_GRP  = 32,
  parameter int unsigned N_CAND = 4,
  parameter int unsigned SEL_W  = 2,
  parameter logic [N_GRP*N_CAND-1:0] HOLES = '0
) (
  input  logic [N_GRP*N_CAND-1:0] pool,
  input  logic [N_GRP*SEL_W-1:0]  sel_vec,
  input  logic [N_GRP-1:0]        grp_en,
  input  logic                    invert,
  output logic                    trip
);
  logic [N_GRP-1:0] picked;
  logic             any_evt;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    trip_xbar_pick #(
      .N_CAND (N_CAND),
      .SEL_W  (SEL_W),
      .HOLE   (HOLES[g*N_CAND +: N_CAND])
    ) u_pick (
      .cand (pool[g*N_CAND +: N_CAND]),
      .sel  (sel_vec[g*SEL_W +: SEL_W]),
      .pick (picked[g])
    );
  end

  assign any_evt = |(picked & grp_en);
  assign trip    = any_evt ^ invert;
endmodule

// File: rtl/trip_route_xbar.sv
`timescale 1ns/1ps
module trip_route_xbar #(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_GRP  = 32,
  parameter int unsigned N_CAND = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter logic [N_GRP*N_CAND-1:0] RSV_MASK =
    (N_GRP*N_CAND)'(trip_xbar_pkg::HOLE_MAP_DEFAULT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic [N_GRP*N_CAND-1:0]  evt_pool,
  output logic [N_OUT-1:0]         trip_out
);
  localparam int unsigned SEL_W = $clog2(N_CAND);

  logic                         rst_core_n;
  logic [N_OUT*N_GRP*SEL_W-1:0] sel_flat;
  logic [N_OUT*N_GRP-1:0]       en_flat;
  logic [N_OUT-1:0]             inv_q;

  trip_xbar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  trip_xbar_regs #(
    .N_OUT  (N_OUT),
    .N_GRP  (N_GRP),
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .sel_flat (sel_flat),
    .en_flat  (en_flat),
    .inv_q    (inv_q)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane
    trip_xbar_lane #(
      .N_GRP  (N_GRP),
      .N_CAND (N_CAND),
      .SEL_W  (SEL_W),
      .HOLES  (RSV_MASK)
    ) u_lane (
      .pool    (evt_pool),
      .sel_vec (sel_flat[o*N_GRP*SEL_W +: N_GRP*SEL_W]),
      .grp_en  (en_flat[o*N_GRP +: N_GRP]),
      .invert  (inv_q[o]),
      .trip    (trip_out[o])
    );
  end
endmodule

// File: rtl/trip_xbar_chk.sv
`timescale 1ns/1ps
module trip_xbar_chk #(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_GRP  = 32,
  parameter int unsigned N_CAND = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter logic [N_GRP*N_CAND-1:0] RSV_MASK = '0
) (
  input  logic                    clk,
  input  logic                    rst_core_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic [N_GRP*N_CAND-1:0] evt_pool,
  input  logic [N_OUT-1:0]        trip_out,
  input  logic [N_OUT-1:0]        inv_q,
  input  logic [N_OUT*N_GRP-1:0]  en_flat
);
  localparam int unsigned SEL_W  = $clog2(N_CAND);
  localparam int unsigned SLOT_W = $clog2(N_GRP / (DATA_W / SEL_W) + 1);
  localparam logic [ADDR_W-1:0] INV_ADDR = ADDR_W'(N_OUT << SLOT_W);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_core_n |-> trip_out == '0);  // R7

  AST_INV_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_we && cfg_addr == INV_ADDR) |=> inv_q == $past(cfg_wdata[N_OUT-1:0]));  // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cfg_we |=> ($stable(inv_q) && $stable(en_flat)));  // R8

  AST_HOLES_SILENT: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((evt_pool & ~RSV_MASK) == '0) |-> trip_out == inv_q);  // R6

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
      (en_flat[o*N_GRP +: N_GRP] == '0) |-> trip_out[o] == inv_q[o]);  // R3
  end
endmodule

bind trip_route_xbar trip_xbar_chk #(
  .N_OUT    (N_OUT),
  .N_GRP    (N_GRP),
  .N_CAND   (N_CAND),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .RSV_MASK (RSV_MASK)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .evt_pool   (evt_pool),
  .trip_out   (trip_out),
  .inv_q      (inv_q),
  .en_flat    (en_flat)
);

// File: tb/trip_route_xbar_bench.sv
`timescale 1ns/1ps
module trip_route_xbar_bench;
  logic         clk;
  logic         rst_n;
  logic         cfg_we;
  logic [5:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic [127:0] evt_pool;
  logic [7:0]   trip_out;

  int checks = 0;
  int fails  = 0;

  // Reference configuration
  logic [31:0] m_lo  [8];
  logic [31:0] m_hi  [8];
  logic [31:0] m_en  [8];
  logic [7:0]  m_inv;

  trip_route_xbar u_trip_route_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .evt_pool  (evt_pool),
    .trip_out  (trip_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // R6 reserved positions
  function automatic bit is_hole(int g, int c);
    if (c == 2 && g >= 16 && ((g % 2) == 0 || g == 31)) return 1'b1;
    if (c == 3 && ((g >= 20 && g <= 24) || g == 26 || g == 28 || g == 30)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] expect_vec();
    logic [7:0] v;
    for (int o = 0; o < 8; o++) begin
      logic any;
      any = 1'b0;
      for (int g = 0; g < 32; g++) begin
        logic [31:0] w;
        int s;
        w = (g < 16) ? m_lo[o] : m_hi[o];
        s = int'(w[2*(g%16) +: 2]);
        if (m_en[o][g] && !is_hole(g, s) && evt_pool[4*g+s]) any = 1'b1;
      end
      v[o] = any ^ m_inv[o];
    end
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] exp);
    checks++;
    if (trip_out !== exp) begin
      fails++;
      $display("FAIL %s: trip_out=%h expected=%h", req, trip_out, exp);
    end
  endtask

  task automatic model_write(logic [5:0] a, logic [31:0] d);
    if (a == 6'd32) m_inv = d[7:0];
    else if (a < 6'd32) begin
      case (a[1:0])
        2'd0: m_lo[a[4:2]] = d;
        2'd1: m_hi[a[4:2]] = d;
        2'd2: m_en[a[4:2]] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic set_pool(logic [127:0] p, string req);
    evt_pool = p;
    #1;
    chk(req, expect_vec());
  endtask

  task automatic t_reset();
    evt_pool = '1;
    #1;
    chk("R7 during reset", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 after release", 8'h00);
  endtask

  task automatic t_select_low();
    wr(6'd14, 32'h1 << 5);
    for (int s = 0; s < 4; s++) begin
      wr(6'd12, 32'(s) << 10);
      set_pool(128'h1 << (20 + s), "R2 low select hit");
      set_pool(128'h1 << (20 + ((s + 1) % 4)), "R2 low select miss");
    end
    chk("R1 others untouched", expect_vec());
  endtask

  task automatic t_select_high();
    wr(6'd25, 32'h1 << 8);
    wr(6'd26, 32'h1 << 20);
    set_pool(128'h1 << 81, "R2 high select hit");
    set_pool(128'h1 << 80, "R2 high select miss");
    set_pool(~(128'h1 << 81), "R2 high select others");
  endtask

  task automatic t_or();
    wr(6'd0, 32'h0);
    wr(6'd1, 32'h1 << 30);
    wr(6'd2, 32'h8000_0001);
    set_pool('0, "R4 none");
    set_pool(128'h1, "R4 group0");
    set_pool(128'h1 << 125, "R4 group31");
    set_pool((128'h1 << 125) | 128'h1, "R4 both");
  endtask

  task automatic t_enable();
    wr(6'd8, 32'h3);
    set_pool('1, "R3 disabled");
    wr(6'd10, 32'h1);
    set_pool('1, "R3 enabled");
    wr(6'd10, 32'h0);
    set_pool('1, "R3 cleared");
  endtask

  task automatic t_invert();
    wr(6'd32, 32'h81);
    set_pool('0, "R5 idle inverted");
    set_pool(128'h1, "R5 or then invert");
    wr(6'd32, 32'h0);
    set_pool('0, "R5 invert cleared");
  endtask

  task automatic t_reserved();
    wr(6'd17, 32'h2 | (32'h2 << 30) | (32'h3 << 12));
    wr(6'd18, 32'h8040_0000 | 32'h1_0000);
    set_pool('1, "R6 holes read zero");
    wr(6'd17, 32'h1);
    set_pool('1, "R6 live neighbour");
  endtask

  task automatic t_unmapped();
    wr(6'd3, '1);
    wr(6'd7, '1);
    wr(6'd33, '1);
    wr(6'd63, '1);
    set_pool('1, "R9 unmapped ignored");
    set_pool('0, "R9 unmapped idle");
  endtask

  task automatic t_latency();
    evt_pool = '0;
    @(negedge clk);
    cfg_addr  = 6'd32;
    cfg_wdata = 32'h40;
    cfg_we    = 1'b1;
    #1;
    chk("R8 before edge", expect_vec());
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(6'd32, 32'h40);
    chk("R8 after edge", expect_vec());
    set_pool(128'h1 << 21, "R8 pool zero latency");
  endtask

  task automatic t_sweep();
    logic [127:0] p;
    p = 128'h9e37_79b9_7f4a_7c15_f39c_c060_5ced_c834;
    for (int i = 0; i < 24; i++) begin
      p = {p[126:0], p[127] ^ p[125] ^ p[100] ^ p[98]};
      set_pool(p, "R4 pattern sweep");
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = '0;
    cfg_wdata = '0;
    evt_pool  = '0;
    m_inv     = '0;
    for (int o = 0; o < 8; o++) begin
      m_lo[o] = '0;
      m_hi[o] = '0;
      m_en[o] = '0;
    end
    t_reset();
    t_select_low();
    t_select_high();
    t_or();
    t_enable();
    t_invert();
    t_reserved();
    t_unmapped();
    t_latency();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule